// File: doc/BRIEF.md
# Predictive Differential Sample Codec

This block compresses a stream of signed sample words into narrow residual words and rebuilds the stream from those residuals. On each sample strobe the encoder guesses the current sample from its history of earlier values and sends only the clipped difference between the sample and that guess. A decoder in the same block keeps its own history and turns each residual back into a sample word. Both results appear one clock after the strobe.

A parameter picks one of two predictors. The first is a weighted sum of the last three values. The second extrapolates a straight line through the last two values. The encoder builds its history from the values the decoder will rebuild, not from the raw inputs. Because of this, the two histories stay equal even when a residual is clipped. The residual port is meant to feed a narrow channel. The reconstructed port shows what a far-end decoder would output.

Top module: `dpcm_codec`

## Requirements
- R1: Reset is synchronous and active high. It clears every history register, drives both valid outputs low and drives both data outputs to zero. The first samples after reset are therefore predicted from a history of zeros.
- R2: With MODE = PRED_3TAP, the prediction is (192·h1 + 51·h2 + 13·h3 + 128) shifted arithmetically right by 8. Here h1, h2 and h3 are the last three reconstructed values, newest first.
- R3: The residual is the sample minus the prediction, clipped to the signed range of RESID_W bits. With RESID_W = 4 that range is −8 to +7. It appears on res_out as two's complement.
- R4: With MODE = PRED_2DIFF, the prediction is 2·h1 − h2.
- R5: The reconstructed value is the prediction plus the clipped residual. It appears on rec_out and becomes the newest history entry.
- R6: The encoder history always equals the decoder history. Each rec_out therefore matches what an independent decoder would rebuild from the res_out stream alone.
- R7: res_vld and rec_vld are high exactly in the clock after a cycle with smp_vld high. Back-to-back strobes give back-to-back valids.
- R8: While smp_vld is low, smp_in has no effect. res_out and rec_out hold their values, and the histories do not advance.
- R9: A reconstructed value outside the SAMPLE_W signed range saturates to −2^(SAMPLE_W−1) or 2^(SAMPLE_W−1)−1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | SAMPLE_W | Signed input sample |
| smp_vld | input | 1 | Sample strobe; one sample per high cycle |
| res_out | output | RESID_W | Clipped signed residual |
| res_vld | output | 1 | Residual valid, one clock after the strobe |
| rec_out | output | SAMPLE_W | Saturated reconstructed sample |
| rec_vld | output | 1 | Reconstructed valid, one clock after the strobe |

## Verification
Saturation of the reconstruction (R9) is the hardest state to reach. A 4-bit residual limits each step to at most seven codes, so the weighted predictor needs hundreds of samples to climb to full scale. The bench therefore holds the input at full scale, then at negative full scale, for several hundred strobes. The line predictor builds up slope during that drive and overshoots, so its clipped correction pushes the sum past the rail. Random full-range samples keep the residual clipped almost all the time, which tests that the encoder and decoder histories still agree (R6).

// File: rtl/dpcm_pkg.sv
package dpcm_pkg;

    typedef enum logic {
        PRED_3TAP  = 1'b0,
        PRED_2DIFF = 1'b1
    } pred_mode_e;

    // Wide signed working type; SAMPLE_W must stay at or below 22 bits.
    typedef logic signed [31:0] acc_t;

    localparam int Q_SHIFT = 8;
    localparam int WT_NEW  = 192;
    localparam int WT_MID  = 51;
    localparam int WT_OLD  = 13;
    localparam int Q_HALF  = 1 << (Q_SHIFT - 1);

    typedef struct packed {
        acc_t n1;
        acc_t n2;
        acc_t n3;
    } taps_t;

    function automatic acc_t lim_hi(int w);
        return (acc_t'(1) <<< (w - 1)) - acc_t'(1);
    endfunction

    function automatic acc_t lim_lo(int w);
        return -(acc_t'(1) <<< (w - 1));
    endfunction

    // Bound a value to the signed range of a w-bit word.
    function automatic acc_t bound_to(acc_t v, int w);
        if (v > lim_hi(w)) return lim_hi(w);
        if (v < lim_lo(w)) return lim_lo(w);
        return v;
    endfunction

endpackage

// File: rtl/dpcm_predictor.sv
module dpcm_predictor
    import dpcm_pkg::*;
#(
    parameter pred_mode_e MODE = PRED_3TAP
) (
    input  taps_t taps_i,
    output acc_t  pred_o
);

    generate
        if (MODE == PRED_3TAP) begin : g_three_tap
            acc_t wsum;
            always_comb begin
                wsum   = acc_t'(WT_NEW) * taps_i.n1
                       + acc_t'(WT_MID) * taps_i.n2
                       + acc_t'(WT_OLD) * taps_i.n3
                       + acc_t'(Q_HALF);
                pred_o = wsum >>> Q_SHIFT;
            end
        end else begin : g_line
            logic unused_oldest;
            assign unused_oldest = ^taps_i.n3;
            always_comb pred_o = (taps_i.n1 <<< 1) - taps_i.n2;
        end
    endgenerate

endmodule

// File: rtl/dpcm_encoder.sv
module dpcm_encoder
    import dpcm_pkg::*;
#(
    parameter int         SAMPLE_W = 12,
    parameter int         RESID_W  = 4,
    parameter pred_mode_e MODE     = PRED_3TAP
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] smp_i,
    input  logic                       smp_vld_i,
    output logic signed [RESID_W-1:0]  res_now_o,
    output logic signed [RESID_W-1:0]  res_q_o,
    output logic                       res_vld_o,
    output logic signed [SAMPLE_W-1:0] hist1_o
);

    logic signed [SAMPLE_W-1:0] h1, h2, h3;
    logic signed [SAMPLE_W-1:0] recon;
    taps_t taps;
    acc_t  pred, diff, resid;

    always_comb begin
        taps.n1 = acc_t'(h1);
        taps.n2 = acc_t'(h2);
        taps.n3 = acc_t'(h3);
    end

    dpcm_predictor #(.MODE(MODE)) pred_i (
        .taps_i (taps),
        .pred_o (pred)
    );

    always_comb begin
        diff      = acc_t'(smp_i) - pred;
        resid     = bound_to(diff, RESID_W);
        recon     = SAMPLE_W'(bound_to(pred + resid, SAMPLE_W));
        res_now_o = RESID_W'(resid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h1        <= '0;
            h2        <= '0;
            h3        <= '0;
            res_q_o   <= '0;
            res_vld_o <= 1'b0;
        end else begin
            res_vld_o <= smp_vld_i;
            if (smp_vld_i) begin
                h1      <= recon;
                h2      <= h1;
                h3      <= h2;
                res_q_o <= res_now_o;
            end
        end
    end

    assign hist1_o = h1;

endmodule

// File: rtl/dpcm_decoder.sv
module dpcm_decoder
    import dpcm_pkg::*;
#(
    parameter int         SAMPLE_W = 12,
    parameter int         RESID_W  = 4,
    parameter pred_mode_e MODE     = PRED_3TAP
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [RESID_W-1:0]  res_i,
    input  logic                       res_vld_i,
    output logic signed [SAMPLE_W-1:0] rec_o,
    output logic                       rec_vld_o
);

    logic signed [SAMPLE_W-1:0] h1, h2, h3;
    logic signed [SAMPLE_W-1:0] rebuilt;
    taps_t taps;
    acc_t  pred;

    always_comb begin
        taps.n1 = acc_t'(h1);
        taps.n2 = acc_t'(h2);
        taps.n3 = acc_t'(h3);
    end

    dpcm_predictor #(.MODE(MODE)) pred_i (
        .taps_i (taps),
        .pred_o (pred)
    );

    always_comb rebuilt = SAMPLE_W'(bound_to(pred + acc_t'(res_i), SAMPLE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            h1        <= '0;
            h2        <= '0;
            h3        <= '0;
            rec_vld_o <= 1'b0;
        end else begin
            rec_vld_o <= res_vld_i;
            if (res_vld_i) begin
                h1 <= rebuilt;
                h2 <= h1;
                h3 <= h2;
            end
        end
    end

    assign rec_o = h1;

endmodule

// File: rtl/dpcm_codec.sv
module dpcm_codec
    import dpcm_pkg::*;
#(
    parameter int         SAMPLE_W = 12,
    parameter int         RESID_W  = 4,
    parameter pred_mode_e MODE     = PRED_3TAP
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] smp_in,
    input  logic                       smp_vld,
    output logic signed [RESID_W-1:0]  res_out,
    output logic                       res_vld,
    output logic signed [SAMPLE_W-1:0] rec_out,
    output logic                       rec_vld
);

    logic signed [RESID_W-1:0]  res_link;
    logic signed [SAMPLE_W-1:0] enc_hist1;

    dpcm_encoder #(
        .SAMPLE_W (SAMPLE_W),
        .RESID_W  (RESID_W),
        .MODE     (MODE)
    ) enc_i (
        .clk       (clk),
        .rst       (rst),
        .smp_i     (smp_in),
        .smp_vld_i (smp_vld),
        .res_now_o (res_link),
        .res_q_o   (res_out),
        .res_vld_o (res_vld),
        .hist1_o   (enc_hist1)
    );

    dpcm_decoder #(
        .SAMPLE_W (SAMPLE_W),
        .RESID_W  (RESID_W),
        .MODE     (MODE)
    ) dec_i (
        .clk       (clk),
        .rst       (rst),
        .res_i     (res_link),
        .res_vld_i (smp_vld),
        .rec_o     (rec_out),
        .rec_vld_o (rec_vld)
    );

endmodule

// File: rtl/dpcm_codec_chk.sv
module dpcm_codec_chk #(
    parameter int SAMPLE_W = 12,
    parameter int RESID_W  = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       smp_vld,
    input logic                       res_vld,
    input logic                       rec_vld,
    input logic signed [RESID_W-1:0]  res_out,
    input logic signed [SAMPLE_W-1:0] rec_out,
    input logic signed [SAMPLE_W-1:0] enc_h1
);

    // R7: a strobe yields both valids in the next clock
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> (res_vld && rec_vld));

    // R7: no valid without a preceding strobe
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> (!res_vld && !rec_vld));

    // R8: idle cycles leave both data outputs unchanged
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> ($stable(res_out) && $stable(rec_out)));

    // R6: encoder history tracks the decoder output
    a_r6_hist_match: assert property (@(posedge clk) disable iff (rst)
        enc_h1 == rec_out);

    // R7: both valid outputs move together
    a_r7_valid_pair: assert property (@(posedge clk) disable iff (rst)
        res_vld == rec_vld);

endmodule

bind dpcm_codec dpcm_codec_chk #(
    .SAMPLE_W (SAMPLE_W),
    .RESID_W  (RESID_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .smp_vld (smp_vld),
    .res_vld (res_vld),
    .rec_vld (rec_vld),
    .res_out (res_out),
    .rec_out (rec_out),
    .enc_h1  (enc_hist1)
);

// File: tb/dpcm_codec_tb_top.sv
module dpcm_codec_tb_top;
    import dpcm_pkg::*;

    localparam int SW = 12;
    localparam int RW = 4;
    localparam int SMAX = (1 << (SW - 1)) - 1;
    localparam int SMIN = -(1 << (SW - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [SW-1:0] smp_in = '0;
    logic smp_vld = 1'b0;
    logic signed [RW-1:0] res_a, res_b;
    logic signed [SW-1:0] rec_a, rec_b;
    logic rv_a, rv_b, cv_a, cv_b;

    always #2.5 clk = ~clk;

    dpcm_codec #(.SAMPLE_W(SW), .RESID_W(RW), .MODE(PRED_3TAP)) dut_i (
        .clk(clk), .rst(rst), .smp_in(smp_in), .smp_vld(smp_vld),
        .res_out(res_a), .res_vld(rv_a), .rec_out(rec_a), .rec_vld(cv_a));

    dpcm_codec #(.SAMPLE_W(SW), .RESID_W(RW), .MODE(PRED_2DIFF)) dut_sd_i (
        .clk(clk), .rst(rst), .smp_in(smp_in), .smp_vld(smp_vld),
        .res_out(res_b), .res_vld(rv_b), .rec_out(rec_b), .rec_vld(cv_b));

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit saw_hi = 0;
    bit saw_lo = 0;
    int mh [2][3];
    int exp_res [2];
    int exp_rec [2];

    function automatic int bnd(int v, int w);
        int hi = (1 << (w - 1)) - 1;
        int lo = -(1 << (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic int guess(int m, int a, int b, int c);
        if (m == 0) return (192 * a + 51 * b + 13 * c + 128) >>> 8;
        return 2 * a - b;
    endfunction

    function automatic void model_step(int x);
        for (int m = 0; m < 2; m++) begin
            int p = guess(m, mh[m][0], mh[m][1], mh[m][2]);
            int r = bnd(x - p, RW);
            int y = bnd(p + r, SW);
            exp_res[m] = r;
            exp_rec[m] = y;
            mh[m][2] = mh[m][1];
            mh[m][1] = mh[m][0];
            mh[m][0] = y;
        end
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic check_outputs(bit vld_exp);
        chk(rv_a == vld_exp, "R7 res_vld 3tap", int'(rv_a), int'(vld_exp));
        chk(cv_a == vld_exp, "R7 rec_vld 3tap", int'(cv_a), int'(vld_exp));
        chk(rv_b == vld_exp, "R7 res_vld 2diff", int'(rv_b), int'(vld_exp));
        chk(cv_b == vld_exp, "R7 rec_vld 2diff", int'(cv_b), int'(vld_exp));
        chk(int'(res_a) == exp_res[0], "R2/R3 residual 3tap", int'(res_a), exp_res[0]);
        chk(int'(rec_a) == exp_rec[0], "R5/R6 rebuilt 3tap", int'(rec_a), exp_rec[0]);
        chk(int'(res_b) == exp_res[1], "R4/R3 residual 2diff", int'(res_b), exp_res[1]);
        chk(int'(rec_b) == exp_rec[1], "R5/R6 rebuilt 2diff", int'(rec_b), exp_rec[1]);
    endtask

    // Called at a negedge; returns at the next negedge with outputs checked.
    task automatic push(int x);
        smp_in  = SW'(x);
        smp_vld = 1'b1;
        @(posedge clk);
        model_step(x);
        @(negedge clk);
        smp_vld = 1'b0;
        check_outputs(1'b1);
        if (int'(rec_b) == SMAX) saw_hi = 1;
        if (int'(rec_b) == SMIN) saw_lo = 1;
    endtask

    // R8: strobe low, garbage on the input, nothing may move
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            smp_in  = SW'($urandom);
            smp_vld = 1'b0;
            @(negedge clk);
            check_outputs(1'b0);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 3; k++) mh[m][k] = 0;
            exp_res[m] = 0;
            exp_rec[m] = 0;
        end
        // R1: everything cleared
        check_outputs(1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1: first samples predicted from zero history
        push(100);
        push(100);
        push(100);
        idle(3);

        // R2/R4: slowly varying signal, mostly unclipped residuals
        begin
            int x = 0;
            for (int i = 0; i < 200; i++) begin
                x = bnd(x + int'($urandom_range(0, 6)) - 3, SW);
                push(x);
            end
        end
        idle(4);

        // R3/R6: full-range random samples keep the residual clipped
        for (int i = 0; i < 300; i++) begin
            push(int'($urandom_range(0, 4095)) - 2048);
            if ((i % 37) == 0) idle(int'($urandom_range(1, 3)));
        end

        // R1: reset mid-stream, history starts over from zero
        do_reset();
        push(-50);
        push(-50);
        push(-50);

        // R9: drive to both rails long enough to saturate
        for (int i = 0; i < 400; i++) push(SMAX);
        for (int i = 0; i < 400; i++) push(SMIN);
        chk(saw_hi, "R9 rebuilt reached upper rail", int'(saw_hi), 1);
        chk(saw_lo, "R9 rebuilt reached lower rail", int'(saw_lo), 1);
        idle(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule